// File: doc/BRIEF.md
# Packed SIMD Multiply-Accumulate Unit

This block multiplies two 64-bit packed vectors lane by lane. It works in one of two lane layouts. The first has eight unsigned 8-bit lanes. The second has four signed 16-bit lanes. Each operation takes one start strobe and completes two clock edges later. The first stage forms and registers the full-width lane products. The second stage does one of three things: narrows the products into the 64-bit vector result, loads them into a 192-bit accumulator, or adds them to that accumulator.

The accumulator holds eight 24-bit elements in the 8-bit layout and four 48-bit elements in the 16-bit layout. Changing the layout does not clear it; the same 192 bits are read under the new element boundaries. A separate clear input zeroes the accumulator. The surrounding datapath chooses the operation per issue. The unit is fully pipelined and accepts a new start every cycle.

Top module: `simd_mac_unit`

## Requirements
- R1: With `fmt`=0, lane i is bits [8i+7:8i] of each source, treated as unsigned, and its full product is 16 bits.
- R2: With `fmt`=1, lane i is bits [16i+15:16i] of each source, treated as two's complement, and its full product is 32 bits.
- R3: With `op`=00 (or 11, which acts the same) and `sat`=0, each result lane holds the low lane-width bits of its product.
- R4: With `op`=00 or 11, `sat`=1 and `fmt`=0, a product above 255 gives lane value 0xFF; otherwise the product itself.
- R5: With `op`=00 or 11, `sat`=1 and `fmt`=1, a product above 32767 gives 0x7FFF, one below -32768 gives 0x8000, and others are kept.
- R6: `op`=01 overwrites every accumulator element with its lane's product. The product is zero-extended to 24 bits at [24i+23:24i] when `fmt`=0, and sign-extended to 48 bits at [48i+47:48i] when `fmt`=1.
- R7: `op`=10 adds the extended product to each accumulator element, modulo 2^24 (`fmt`=0) or 2^48 (`fmt`=1).
- R8: A change of `fmt` leaves the accumulator bits as they are; the next accumulate operation reads them under the new element boundaries.
- R9: `acc_clr` high in a cycle zeroes the accumulator at the next edge. If an accumulate operation is in its second stage at that edge, it is applied to the zeroed value.
- R10: `done` is high for exactly one cycle, two edges after each start, including back-to-back starts. `result` changes only when a multiply (00/11) completes. The accumulator changes only through an accumulate operation or a clear.
- R11: While `rst` is high at a clock edge, `result`, `acc_out` and `done` become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Issue strobe; captures sources and controls |
| op | input | 2 | 00 multiply, 01 load accumulator, 10 multiply-accumulate, 11 multiply |
| fmt | input | 1 | 0: eight unsigned 8-bit lanes, 1: four signed 16-bit lanes |
| sat | input | 1 | 1 saturates the narrowed result, 0 wraps it |
| acc_clr | input | 1 | Zeroes the accumulator |
| src_a | input | 64 | First packed source |
| src_b | input | 64 | Second packed source |
| result | output | 64 | Narrowed multiply result |
| acc_out | output | 192 | Accumulator contents |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two actions can land on the accumulator at the same edge: a clear, and the second stage of a load or multiply-accumulate. The bench provokes this by raising `acc_clr` in the cycle right after the start of a multiply-accumulate. It expects that operation to leave only the extended products in the accumulator, as if the old contents had been zero. A clear on its own is also checked for a zero accumulator. Long back-to-back accumulate runs push the 24-bit elements past their wrap point.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;

    localparam int VEC_W   = 64;
    localparam int NB_W    = 8;
    localparam int WB_W    = 16;
    localparam int NB_ACC  = 24;
    localparam int WB_ACC  = 48;
    localparam int PROD_W  = 2 * VEC_W;
    localparam int ACC_W   = (VEC_W / NB_W) * NB_ACC;

    typedef enum logic [1:0] {
        OP_MUL     = 2'b00,
        OP_LOAD    = 2'b01,
        OP_MAC     = 2'b10,
        OP_MUL_ALT = 2'b11
    } mac_op_e;

    typedef enum logic {
        FMT_U8  = 1'b0,
        FMT_S16 = 1'b1
    } lane_fmt_e;

    typedef struct packed {
        logic      valid;
        mac_op_e   op;
        lane_fmt_e fmt;
        logic      sat;
    } stage_ctl_t;

    function automatic logic is_acc_op(mac_op_e op);
        return (op == OP_LOAD) || (op == OP_MAC);
    endfunction

    // Unsigned narrowing: clamp to all-ones if any upper bit is set.
    function automatic logic [NB_W-1:0] narrow_u(logic [2*NB_W-1:0] p, logic sat);
        if (sat && (|p[2*NB_W-1:NB_W]))
            return '1;
        return p[NB_W-1:0];
    endfunction

    // Signed narrowing: in range when all bits from the lane sign bit up agree.
    function automatic logic [WB_W-1:0] narrow_s(logic [2*WB_W-1:0] p, logic sat);
        logic fits;
        fits = (&p[2*WB_W-1:WB_W-1]) | ~(|p[2*WB_W-1:WB_W-1]);
        if (!sat || fits)
            return p[WB_W-1:0];
        return p[2*WB_W-1] ? {1'b1, {(WB_W-1){1'b0}}} : {1'b0, {(WB_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/simd_lane_mul.sv
module simd_lane_mul
    import simd_mac_pkg::*;
#(
    parameter int DW = VEC_W,
    parameter int NW = NB_W,
    parameter int WW = WB_W
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  lane_fmt_e       fmt,
    output logic [2*DW-1:0] prod
);
    localparam int NLN = DW / NW;
    localparam int WLN = DW / WW;

    logic [2*DW-1:0] prod_n;
    logic [2*DW-1:0] prod_w;

    // Unsigned narrow lanes: zero-extend then multiply, product fits exactly.
    for (genvar g = 0; g < NLN; g++) begin : g_nlane
        logic [2*NW-1:0] ax;
        logic [2*NW-1:0] bx;
        assign ax = {{NW{1'b0}}, a[g*NW +: NW]};
        assign bx = {{NW{1'b0}}, b[g*NW +: NW]};
        assign prod_n[g*2*NW +: 2*NW] = ax * bx;
    end

    // Signed wide lanes: sign-extend then multiply, low bits are exact.
    for (genvar g = 0; g < WLN; g++) begin : g_wlane
        logic signed [2*WW-1:0] ax;
        logic signed [2*WW-1:0] bx;
        assign ax = {{WW{a[g*WW+WW-1]}}, a[g*WW +: WW]};
        assign bx = {{WW{b[g*WW+WW-1]}}, b[g*WW +: WW]};
        assign prod_w[g*2*WW +: 2*WW] = ax * bx;
    end

    assign prod = (fmt == FMT_U8) ? prod_n : prod_w;

endmodule

// File: rtl/simd_narrow.sv
module simd_narrow
    import simd_mac_pkg::*;
#(
    parameter int DW = VEC_W,
    parameter int NW = NB_W,
    parameter int WW = WB_W
) (
    input  logic [2*DW-1:0] prod,
    input  lane_fmt_e       fmt,
    input  logic            sat,
    output logic [DW-1:0]   res
);
    localparam int NLN = DW / NW;
    localparam int WLN = DW / WW;

    logic [DW-1:0] res_n;
    logic [DW-1:0] res_w;

    for (genvar g = 0; g < NLN; g++) begin : g_nlane
        assign res_n[g*NW +: NW] = narrow_u(prod[g*2*NW +: 2*NW], sat);
    end

    for (genvar g = 0; g < WLN; g++) begin : g_wlane
        assign res_w[g*WW +: WW] = narrow_s(prod[g*2*WW +: 2*WW], sat);
    end

    assign res = (fmt == FMT_U8) ? res_n : res_w;

endmodule

// File: rtl/simd_acc_update.sv
module simd_acc_update
    import simd_mac_pkg::*;
#(
    parameter int DW = VEC_W,
    parameter int NW = NB_W,
    parameter int WW = WB_W,
    parameter int NA = NB_ACC,
    parameter int WA = WB_ACC
) (
    input  logic [(DW/NW)*NA-1:0] acc_cur,
    input  logic                  clr,
    input  logic                  en,
    input  mac_op_e               op,
    input  lane_fmt_e             fmt,
    input  logic [2*DW-1:0]       prod,
    output logic [(DW/NW)*NA-1:0] acc_nxt
);
    localparam int NLN  = DW / NW;
    localparam int WLN  = DW / WW;
    localparam int AW   = NLN * NA;
    localparam int NPAD = NA - 2*NW;
    localparam int WPAD = WA - 2*WW;

    logic [AW-1:0] base;
    logic          keep;
    logic [AW-1:0] sum_n;
    logic [AW-1:0] sum_w;

    // A clear in the same cycle zeroes the value the operation builds on.
    assign base = clr ? '0 : acc_cur;
    assign keep = (op == OP_MAC);

    for (genvar g = 0; g < NLN; g++) begin : g_nelem
        logic [NA-1:0] ext;
        logic [NA-1:0] addend;
        assign ext    = {{NPAD{1'b0}}, prod[g*2*NW +: 2*NW]};
        assign addend = keep ? base[g*NA +: NA] : '0;
        assign sum_n[g*NA +: NA] = addend + ext;
    end

    for (genvar g = 0; g < WLN; g++) begin : g_welem
        logic [WA-1:0] ext;
        logic [WA-1:0] addend;
        assign ext    = {{WPAD{prod[g*2*WW+2*WW-1]}}, prod[g*2*WW +: 2*WW]};
        assign addend = keep ? base[g*WA +: WA] : '0;
        assign sum_w[g*WA +: WA] = addend + ext;
    end

    always_comb begin
        if (!en)
            acc_nxt = base;
        else if (fmt == FMT_U8)
            acc_nxt = sum_n;
        else
            acc_nxt = sum_w;
    end

endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
    import simd_mac_pkg::*;
#(
    parameter int DW = VEC_W,
    parameter int NW = NB_W,
    parameter int WW = WB_W,
    parameter int NA = NB_ACC,
    parameter int WA = WB_ACC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [1:0]            op,
    input  logic                  fmt,
    input  logic                  sat,
    input  logic                  acc_clr,
    input  logic [DW-1:0]         src_a,
    input  logic [DW-1:0]         src_b,
    output logic [DW-1:0]         result,
    output logic [(DW/NW)*NA-1:0] acc_out,
    output logic                  done
);
    localparam int PW = 2 * DW;
    localparam int AW = (DW / NW) * NA;

    stage_ctl_t    s1_ctl;
    logic [PW-1:0] s1_prod;
    logic [PW-1:0] prod_c;
    logic [DW-1:0] narrow_c;
    logic [AW-1:0] acc_c;
    logic [DW-1:0] result_q;
    logic [AW-1:0] acc_q;
    logic          done_q;
    logic          s2_is_acc;
    logic          s2_is_mul;

    // Stage 1: lane products.
    simd_lane_mul #(.DW(DW), .NW(NW), .WW(WW)) u_mul (
        .a    (src_a),
        .b    (src_b),
        .fmt  (lane_fmt_e'(fmt)),
        .prod (prod_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ctl  <= '0;
            s1_prod <= '0;
        end else begin
            s1_ctl.valid <= start;
            if (start) begin
                s1_ctl.op  <= mac_op_e'(op);
                s1_ctl.fmt <= lane_fmt_e'(fmt);
                s1_ctl.sat <= sat;
                s1_prod    <= prod_c;
            end
        end
    end

    // Stage 2: narrow for the vector result, or accumulate.
    assign s2_is_acc = s1_ctl.valid && is_acc_op(s1_ctl.op);
    assign s2_is_mul = s1_ctl.valid && !is_acc_op(s1_ctl.op);

    simd_narrow #(.DW(DW), .NW(NW), .WW(WW)) u_narrow (
        .prod (s1_prod),
        .fmt  (s1_ctl.fmt),
        .sat  (s1_ctl.sat),
        .res  (narrow_c)
    );

    simd_acc_update #(.DW(DW), .NW(NW), .WW(WW), .NA(NA), .WA(WA)) u_acc (
        .acc_cur (acc_q),
        .clr     (acc_clr),
        .en      (s2_is_acc),
        .op      (s1_ctl.op),
        .fmt     (s1_ctl.fmt),
        .prod    (s1_prod),
        .acc_nxt (acc_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            acc_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= s1_ctl.valid;
            acc_q  <= acc_c;
            if (s2_is_mul)
                result_q <= narrow_c;
        end
    end

    assign result  = result_q;
    assign acc_out = acc_q;
    assign done    = done_q;

endmodule

// File: rtl/simd_mac_unit_chk.sv
module simd_mac_unit_chk #(
    parameter int DW = 64,
    parameter int NW = 8,
    parameter int NA = 24
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic [1:0]            op,
    input logic                  fmt,
    input logic                  acc_clr,
    input logic [DW-1:0]         result,
    input logic [(DW/NW)*NA-1:0] acc_out,
    input logic                  done
);
    localparam int NLN = DW / NW;

    logic [1:0]     age;
    logic [NLN-1:0] hi_bits;
    logic           hi_any;

    always_ff @(posedge clk) begin
        if (rst)
            age <= 2'd0;
        else if (age != 2'd2)
            age <= age + 2'd1;
    end

    for (genvar g = 0; g < NLN; g++) begin : g_hi
        assign hi_bits[g] = |acc_out[g*NA + 2*NW +: NA - 2*NW];
    end
    assign hi_any = |hi_bits;

    // R10: every start completes two edges later.
    a_r10_done_latency: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past(start, 2)) |-> done);

    // R10: no completion without a matching start.
    a_r10_done_cause: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && done) |-> $past(start, 2));

    // R10: result moves only on multiply completion.
    a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && !($past(start, 2) && ($past(op, 2) == 2'b00 || $past(op, 2) == 2'b11)))
        |-> $stable(result));

    // R10: a multiply leaves the accumulator alone.
    a_r10_mul_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past(start, 2) && ($past(op, 2) == 2'b00 || $past(op, 2) == 2'b11)
         && !$past(acc_clr)) |-> $stable(acc_out));

    // R9: a clear with no accumulate in flight leaves zero.
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && $past(acc_clr)
         && !(age == 2'd2 && $past(start, 2) && ($past(op, 2) == 2'b01 || $past(op, 2) == 2'b10)))
        |-> (acc_out == '0));

    // R6: a byte-format load leaves the element top bits clear.
    a_r6_load_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past(start, 2) && $past(op, 2) == 2'b01 && $past(fmt, 2) == 1'b0)
        |-> !hi_any);

endmodule

bind simd_mac_unit simd_mac_unit_chk #(.DW(DW), .NW(NW), .NA(NA)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op      (op),
    .fmt     (fmt),
    .acc_clr (acc_clr),
    .result  (result),
    .acc_out (acc_out),
    .done    (done)
);

// File: tb/simd_mac_unit_test.sv
`timescale 1ns/1ps
module simd_mac_unit_test;

    typedef struct {
        logic [63:0]  res;
        logic [191:0] acc;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   op = 2'b00;
    logic         fmt = 1'b0;
    logic         sat = 1'b0;
    logic         acc_clr = 1'b0;
    logic [63:0]  src_a = '0;
    logic [63:0]  src_b = '0;
    logic [63:0]  result;
    logic [191:0] acc_out;
    logic         done;

    logic [191:0] m_acc = '0;
    logic [63:0]  m_res = '0;
    exp_t         sb[$];
    int           n_cmp = 0;
    int           n_bad = 0;
    int           n_start = 0;
    int           n_done = 0;

    always #4 clk = ~clk;

    simd_mac_unit uut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op      (op),
        .fmt     (fmt),
        .sat     (sat),
        .acc_clr (acc_clr),
        .src_a   (src_a),
        .src_b   (src_b),
        .result  (result),
        .acc_out (acc_out),
        .done    (done)
    );

    task automatic chk(input string tag, input string what,
                       input logic [191:0] act, input logic [191:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Reference model built from the requirements.
    task automatic model_step(input logic [1:0] o, input logic f, input logic s,
                              input logic [63:0] x, input logic [63:0] y, input logic clr);
        bit acc_op;
        bit keep;
        acc_op = (o == 2'b01) || (o == 2'b10);
        keep   = (o == 2'b10);
        if (clr) m_acc = '0;
        if (!f) begin
            for (int i = 0; i < 8; i++) begin
                int p;
                logic [31:0] pv;
                p  = int'(x[8*i +: 8]) * int'(y[8*i +: 8]);
                pv = p;
                if (acc_op)
                    m_acc[24*i +: 24] = (keep ? m_acc[24*i +: 24] : 24'd0) + pv[23:0];
                else
                    m_res[8*i +: 8] = (s && p > 255) ? 8'hFF : pv[7:0];
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                longint p;
                logic [63:0] pv;
                p  = longint'($signed(x[16*i +: 16])) * longint'($signed(y[16*i +: 16]));
                pv = p;
                if (acc_op)
                    m_acc[48*i +: 48] = (keep ? m_acc[48*i +: 48] : 48'd0) + pv[47:0];
                else if (s && p > 32767)
                    m_res[16*i +: 16] = 16'h7FFF;
                else if (s && p < -32768)
                    m_res[16*i +: 16] = 16'h8000;
                else
                    m_res[16*i +: 16] = pv[15:0];
            end
        end
    endtask

    // Driver: issues one operation and queues its expected outcome.
    task automatic issue(input logic [1:0] o, input logic f, input logic s,
                         input logic [63:0] x, input logic [63:0] y,
                         input logic clr, input bit idle, input string tag);
        exp_t e;
        @(negedge clk);
        start = 1'b1; op = o; fmt = f; sat = s; src_a = x; src_b = y; acc_clr = 1'b0;
        model_step(o, f, s, x, y, clr);
        e.res = m_res; e.acc = m_acc; e.tag = tag;
        sb.push_back(e);
        n_start++;
        if (idle) begin
            @(negedge clk);
            start = 1'b0; acc_clr = clr;
            @(negedge clk);
            acc_clr = 1'b0;
        end
    endtask

    task automatic drain();
        @(negedge clk);
        start = 1'b0; acc_clr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compares each completion against the queue head.
    always @(negedge clk) begin
        if (!rst && done) begin
            n_done++;
            if (sb.size() == 0) begin
                chk("R10", "done without start", 192'd1, 192'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "result", {128'd0, result}, {128'd0, e.res});
                chk(e.tag, "acc", acc_out, e.acc);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R10 watchdog expired act=%0d exp=%0d", n_done, n_start);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state.
        chk("R11", "result", {128'd0, result}, 192'd0);
        chk("R11", "acc", acc_out, 192'd0);
        chk("R11", "done", {191'd0, done}, 192'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R3 R4: unsigned byte lanes, wrap then saturate.
        issue(2'b00, 1'b0, 1'b0, 64'h1122_3344_FF80_0210, 64'h0F02_1020_FF02_8008, 1'b0, 1'b1, "R1/R3");
        issue(2'b00, 1'b0, 1'b1, 64'h1122_3344_FF80_0210, 64'h0F02_1020_FF02_8008, 1'b0, 1'b1, "R4");
        // R2 R3 R5: signed halfword lanes with extremes.
        issue(2'b00, 1'b1, 1'b0, 64'h8000_7FFF_FFFD_0123, 64'h8000_7FFF_0005_0456, 1'b0, 1'b1, "R2/R3");
        issue(2'b00, 1'b1, 1'b1, 64'h8000_7FFF_FFFD_0123, 64'h8000_7FFF_0005_0456, 1'b0, 1'b1, "R5");
        issue(2'b00, 1'b1, 1'b1, 64'h8000_0100_7FFF_FF00, 64'h7FFF_0100_8000_0100, 1'b0, 1'b1, "R5");
        // R3: alternate multiply encoding.
        issue(2'b11, 1'b0, 1'b1, 64'hFFFF_0101_8040_2001, 64'h0203_FF7F_0204_0810, 1'b0, 1'b1, "R3");
        // R6: load, byte format.
        issue(2'b01, 1'b0, 1'b0, 64'hFFFF_0101_8040_2001, 64'hFF03_FF7F_0204_0810, 1'b0, 1'b1, "R6");
        // R7 R10: back-to-back accumulate with a multiply in between.
        issue(2'b10, 1'b0, 1'b0, 64'h0102_0304_0506_0708, 64'h1112_1314_1516_1718, 1'b0, 1'b0, "R7");
        issue(2'b10, 1'b0, 1'b0, 64'hFF00_FF00_FF00_FF00, 64'hFFFF_0000_FFFF_0000, 1'b0, 1'b0, "R7");
        issue(2'b00, 1'b0, 1'b0, 64'h0A0A_0A0A_0A0A_0A0A, 64'h0303_0303_0303_0303, 1'b0, 1'b0, "R10");
        issue(2'b10, 1'b0, 1'b0, 64'h0203_0405_0607_0809, 64'h0909_0909_0909_0909, 1'b0, 1'b1, "R7");
        // R7: drive the 24-bit elements past their wrap point.
        for (int k = 0; k < 260; k++)
            issue(2'b10, 1'b0, 1'b0, '1, '1, 1'b0, 1'b0, "R7");
        drain();
        // R8: halfword accumulate on top of byte-layout contents.
        issue(2'b10, 1'b1, 1'b0, 64'h8000_7FFF_FFFD_0123, 64'h8000_7FFF_0005_0456, 1'b0, 1'b1, "R8");
        // R6 R7: halfword load then signed accumulation.
        issue(2'b01, 1'b1, 1'b0, 64'hFFFF_8000_0003_1234, 64'h0001_0002_FFFF_FFFE, 1'b0, 1'b1, "R6");
        for (int k = 0; k < 3; k++)
            issue(2'b10, 1'b1, 1'b0, 64'hC000_8000_FF00_7FFF, 64'h7FFF_8000_0100_8000, 1'b0, 1'b0, "R7");
        drain();
        // R9: clear in the same cycle as an accumulate's second stage.
        issue(2'b10, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'h0102_0304_0506_0708, 1'b1, 1'b1, "R9");
        drain();
        // R9: clear on its own.
        @(negedge clk);
        acc_clr = 1'b1;
        @(negedge clk);
        acc_clr = 1'b0;
        m_acc = '0;
        chk("R9", "acc after clear", acc_out, 192'd0);
        chk("R10", "result kept through clear", {128'd0, result}, {128'd0, m_res});
        issue(2'b10, 1'b1, 1'b0, 64'h0002_FFFF_1000_8001, 64'h0003_0003_1000_8001, 1'b0, 1'b1, "R7");
        drain();
        // R10: one completion per start, nothing left pending.
        chk("R10", "done count", 192'(n_done), 192'(n_start));
        chk("R10", "pending items", 192'(sb.size()), 192'd0);
        summary();
        $finish;
    end

endmodule